// File: doc/BRIEF.md
# Undo-Log Checkpoint Recovery Unit

This unit sits next to a small processor's general register file, its data memory and its special registers (program counter, status and similar). Whenever the processor overwrites one of these locations, it reports the address and the value being replaced. The unit keeps that old value in a last-in, first-out log, with one log for each class of state. After a transient fault, the state can then be wound back to the most recent checkpoint.

A checkpoint commit discards all three logs in a single cycle. Recovery is requested separately for each class by one of three commands. The unit then replays the class's log newest entry first, one restore write per cycle, through a write port dedicated to that class. A location written several times therefore ends up holding its checkpointed value.

General and special registers carry one dirty bit per register, so only the first overwrite after a checkpoint is logged. Each log's depth is a parameter. A log that fills up raises a sticky overflow flag, and a later recovery of that class is refused and reported as invalid.

Top module: `ckpt_undo_unit`

## Requirements
- R1: After reset, busy, done, rcv_invalid, all three restore write enables and log_ovf are 0.
- R2: While idle, each accepted write notification stores its address and old value. A recovery command sampled at clock edge E0 makes busy 1 after E0. The class's entries are then emitted on that class's restore port, one per cycle and newest first, with the first write visible after E1.
- R3: Every data memory write is logged, including repeated writes to one address. The last restore write to an address carries the old value from that address's earliest write since the checkpoint.
- R4: A general or special register already logged since the last checkpoint or the last recovery of its class is not logged again. After a recovery of that class, the register is logged again on its next write.
- R5: A commit while idle empties all three logs, clears all dirty bits and clears log_ovf, all in one cycle. A write notified in the same cycle as the commit is logged as the first entry of the new interval.
- R6: Each command restores only its own class. If several commands arrive in the same cycle, priority is general registers, then data memory, then special registers, and the losing commands are dropped. At most one restore write enable is high in any cycle.
- R7: A recovery of N entries raises done for exactly one cycle, N+1 cycles after the command edge, and busy falls at the same time. With the default depths, full-capacity recovery of all three classes back to back, counting each command cycle, takes at most 62 cycles.
- R8: A push into a full log drops the entry and sets that class's log_ovf bit (bit 0 general registers, bit 1 data memory, bit 2 special registers). A command for an overflowed class gives done and rcv_invalid one cycle later, with no restore writes and without busy.
- R9: While busy, write notifications, commit and further recovery commands have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gpr_wr_vld | input | 1 | General register overwrite notification |
| gpr_wr_addr | input | REG_AW | Register being overwritten |
| gpr_wr_old | input | DW | Value being replaced |
| mem_wr_vld | input | 1 | Data memory overwrite notification |
| mem_wr_addr | input | MEM_AW | Word address being overwritten |
| mem_wr_old | input | DW | Value being replaced |
| spr_wr_vld | input | 1 | Special register overwrite notification |
| spr_wr_addr | input | SPR_AW | Special register being overwritten |
| spr_wr_old | input | DW | Value being replaced |
| commit | input | 1 | Checkpoint commit strobe |
| rcv_gpr | input | 1 | Recover general registers |
| rcv_mem | input | 1 | Recover data memory |
| rcv_spr | input | 1 | Recover special registers |
| gpr_rst_we | output | 1 | General register restore write enable |
| gpr_rst_addr | output | REG_AW | Restore address |
| gpr_rst_data | output | DW | Restore value |
| mem_rst_we | output | 1 | Data memory restore write enable |
| mem_rst_addr | output | MEM_AW | Restore address |
| mem_rst_data | output | DW | Restore value |
| spr_rst_we | output | 1 | Special register restore write enable |
| spr_rst_addr | output | SPR_AW | Restore address |
| spr_rst_data | output | DW | Restore value |
| busy | output | 1 | Recovery in progress |
| done | output | 1 | One-cycle recovery completion pulse |
| rcv_invalid | output | 1 | Completed recovery was refused due to overflow |
| log_ovf | output | 3 | Sticky per-class overflow flags |

## Verification
A wrong log count or stack pointer shows up as a missing, extra or reordered restore write on the class port. The done pulse then arrives in a cycle other than N+1, so the error is visible within the same recovery. A wrong dirty bit shows as a duplicated or absent register entry. Leftover state after a commit shows as restore writes where none should appear, and a leaked overflow flag shows as an unexpected rcv_invalid one cycle after the next command.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;

    localparam int CLS_GPR = 0;
    localparam int CLS_MEM = 1;
    localparam int CLS_SPR = 2;
    localparam int NCLS    = 3;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/undo_lifo.sv
module undo_lifo #(
    parameter int AW    = 4,
    parameter int DW    = 16,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [AW-1:0] top_addr,
    output logic [DW-1:0] top_data,
    output logic          empty,
    output logic          ovf
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int EW = AW + DW;

    typedef struct packed {
        logic [DEPTH-1:0][EW-1:0] mem;
        logic [CW-1:0]            cnt;
        logic                     ovf;
    } lifo_t;

    lifo_t         s_q, s_d;
    logic [CW-1:0] base;
    logic [CW-1:0] top_ptr;
    logic          full;

    always_comb begin
        s_d  = s_q;
        base = s_q.cnt;
        if (clr) begin
            s_d.cnt = '0;
            s_d.ovf = 1'b0;
            base    = '0;
        end else if (pop && (s_q.cnt != '0)) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
        full = (base == CW'(DEPTH));
        if (push) begin
            if (full) begin
                s_d.ovf = 1'b1;
            end else begin
                s_d.mem[base[IW-1:0]] = {push_addr, push_data};
                s_d.cnt               = base + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign top_ptr = s_q.cnt - 1'b1;
    assign {top_addr, top_data} = s_q.mem[top_ptr[IW-1:0]];
    assign empty = (s_q.cnt == '0);
    assign ovf   = s_q.ovf;

endmodule

// File: rtl/dirty_filter.sv
module dirty_filter #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          mark,
    input  logic [AW-1:0] addr,
    output logic          hit
);
    localparam int N = 1 << AW;

    logic [N-1:0] bits_q, bits_d;

    always_comb begin
        bits_d = bits_q;
        if (clr)  bits_d       = '0;
        if (mark) bits_d[addr] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    assign hit = bits_q[addr];

endmodule

// File: rtl/restore_seq.sv
module restore_seq
    import ckpt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCLS-1:0] cmd,
    input  logic [NCLS-1:0] ovf,
    input  logic [NCLS-1:0] empty,
    output logic [NCLS-1:0] pop,
    output logic [1:0]      cls,
    output logic            fin,
    output logic            busy,
    output logic            done,
    output logic            invalid
);
    typedef struct packed {
        seq_state_e st;
        logic [1:0] cls;
        logic       done;
        logic       invalid;
    } seq_t;

    seq_t       s_q, s_d;
    logic [1:0] pick;

    always_comb begin
        s_d         = s_q;
        s_d.done    = 1'b0;
        s_d.invalid = 1'b0;
        pop         = '0;
        fin         = 1'b0;
        pick        = cmd[CLS_GPR] ? 2'(CLS_GPR) :
                      cmd[CLS_MEM] ? 2'(CLS_MEM) : 2'(CLS_SPR);
        case (s_q.st)
            SEQ_IDLE: begin
                if (|cmd) begin
                    if (ovf[pick]) begin
                        s_d.done    = 1'b1;
                        s_d.invalid = 1'b1;
                    end else begin
                        s_d.st  = SEQ_RUN;
                        s_d.cls = pick;
                    end
                end
            end
            default: begin
                if (!empty[s_q.cls]) begin
                    pop[s_q.cls] = 1'b1;
                end else begin
                    fin      = 1'b1;
                    s_d.st   = SEQ_IDLE;
                    s_d.done = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: SEQ_IDLE, cls: 2'd0, done: 1'b0, invalid: 1'b0};
        else        s_q <= s_d;
    end

    assign cls     = s_q.cls;
    assign busy    = (s_q.st == SEQ_RUN);
    assign done    = s_q.done;
    assign invalid = s_q.invalid;

endmodule

// File: rtl/ckpt_undo_unit.sv
module ckpt_undo_unit
    import ckpt_pkg::*;
#(
    parameter int REG_AW     = 4,
    parameter int MEM_AW     = 8,
    parameter int SPR_AW     = 2,
    parameter int DW         = 16,
    parameter int GPR_DEPTH  = 8,
    parameter int MEM_DEPTH  = 8,
    parameter int SPR_DEPTH  = 4,
    parameter bit SPR_FILTER = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gpr_wr_vld,
    input  logic [REG_AW-1:0] gpr_wr_addr,
    input  logic [DW-1:0]     gpr_wr_old,
    input  logic              mem_wr_vld,
    input  logic [MEM_AW-1:0] mem_wr_addr,
    input  logic [DW-1:0]     mem_wr_old,
    input  logic              spr_wr_vld,
    input  logic [SPR_AW-1:0] spr_wr_addr,
    input  logic [DW-1:0]     spr_wr_old,
    input  logic              commit,
    input  logic              rcv_gpr,
    input  logic              rcv_mem,
    input  logic              rcv_spr,
    output logic              gpr_rst_we,
    output logic [REG_AW-1:0] gpr_rst_addr,
    output logic [DW-1:0]     gpr_rst_data,
    output logic              mem_rst_we,
    output logic [MEM_AW-1:0] mem_rst_addr,
    output logic [DW-1:0]     mem_rst_data,
    output logic              spr_rst_we,
    output logic [SPR_AW-1:0] spr_rst_addr,
    output logic [DW-1:0]     spr_rst_data,
    output logic              busy,
    output logic              done,
    output logic              rcv_invalid,
    output logic [2:0]        log_ovf
);
    typedef struct packed {
        logic [NCLS-1:0]   we;
        logic [REG_AW-1:0] g_addr;
        logic [DW-1:0]     g_data;
        logic [MEM_AW-1:0] m_addr;
        logic [DW-1:0]     m_data;
        logic [SPR_AW-1:0] s_addr;
        logic [DW-1:0]     s_data;
    } rst_out_t;

    logic              commit_eff;
    logic              gpr_ok, mem_ok, spr_ok;
    logic              gpr_push, mem_push, spr_push;
    logic              gpr_hit;
    logic [NCLS-1:0]   lg_empty;
    logic [NCLS-1:0]   lg_ovf;
    logic [NCLS-1:0]   pop;
    logic [1:0]        run_cls;
    logic              run_fin;
    logic              clr_gpr_dirty, clr_spr_dirty;
    logic [REG_AW-1:0] g_top_addr;
    logic [DW-1:0]     g_top_data;
    logic [MEM_AW-1:0] m_top_addr;
    logic [DW-1:0]     m_top_data;
    logic [SPR_AW-1:0] s_top_addr;
    logic [DW-1:0]     s_top_data;
    rst_out_t          o_q, o_d;

    // notifications and commit only count while no recovery is running
    assign commit_eff    = commit & ~busy;
    assign gpr_ok        = gpr_wr_vld & ~busy;
    assign mem_ok        = mem_wr_vld & ~busy;
    assign spr_ok        = spr_wr_vld & ~busy;
    assign clr_gpr_dirty = commit_eff | (run_fin & (run_cls == 2'(CLS_GPR)));
    assign clr_spr_dirty = commit_eff | (run_fin & (run_cls == 2'(CLS_SPR)));

    // a same-cycle commit wipes the dirty bit, so the write opens the new interval
    assign gpr_push = gpr_ok & (~gpr_hit | commit_eff);
    assign mem_push = mem_ok;

    dirty_filter #(.AW(REG_AW)) u_gpr_dirty (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_gpr_dirty),
        .mark  (gpr_push),
        .addr  (gpr_wr_addr),
        .hit   (gpr_hit)
    );

    generate
        if (SPR_FILTER) begin : g_spr_filt
            logic spr_hit;
            dirty_filter #(.AW(SPR_AW)) u_spr_dirty (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (clr_spr_dirty),
                .mark  (spr_push),
                .addr  (spr_wr_addr),
                .hit   (spr_hit)
            );
            assign spr_push = spr_ok & (~spr_hit | commit_eff);
        end else begin : g_spr_raw
            logic unused_clr;
            assign unused_clr = clr_spr_dirty;
            assign spr_push   = spr_ok;
        end
    endgenerate

    undo_lifo #(.AW(REG_AW), .DW(DW), .DEPTH(GPR_DEPTH)) u_gpr_log (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (commit_eff),
        .push      (gpr_push),
        .push_addr (gpr_wr_addr),
        .push_data (gpr_wr_old),
        .pop       (pop[CLS_GPR]),
        .top_addr  (g_top_addr),
        .top_data  (g_top_data),
        .empty     (lg_empty[CLS_GPR]),
        .ovf       (lg_ovf[CLS_GPR])
    );

    undo_lifo #(.AW(MEM_AW), .DW(DW), .DEPTH(MEM_DEPTH)) u_mem_log (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (commit_eff),
        .push      (mem_push),
        .push_addr (mem_wr_addr),
        .push_data (mem_wr_old),
        .pop       (pop[CLS_MEM]),
        .top_addr  (m_top_addr),
        .top_data  (m_top_data),
        .empty     (lg_empty[CLS_MEM]),
        .ovf       (lg_ovf[CLS_MEM])
    );

    undo_lifo #(.AW(SPR_AW), .DW(DW), .DEPTH(SPR_DEPTH)) u_spr_log (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (commit_eff),
        .push      (spr_push),
        .push_addr (spr_wr_addr),
        .push_data (spr_wr_old),
        .pop       (pop[CLS_SPR]),
        .top_addr  (s_top_addr),
        .top_data  (s_top_data),
        .empty     (lg_empty[CLS_SPR]),
        .ovf       (lg_ovf[CLS_SPR])
    );

    restore_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     ({rcv_spr, rcv_mem, rcv_gpr}),
        .ovf     (lg_ovf),
        .empty   (lg_empty),
        .pop     (pop),
        .cls     (run_cls),
        .fin     (run_fin),
        .busy    (busy),
        .done    (done),
        .invalid (rcv_invalid)
    );

    always_comb begin
        o_d        = o_q;
        o_d.we     = pop;
        o_d.g_addr = g_top_addr;
        o_d.g_data = g_top_data;
        o_d.m_addr = m_top_addr;
        o_d.m_data = m_top_data;
        o_d.s_addr = s_top_addr;
        o_d.s_data = s_top_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign gpr_rst_we   = o_q.we[CLS_GPR];
    assign gpr_rst_addr = o_q.g_addr;
    assign gpr_rst_data = o_q.g_data;
    assign mem_rst_we   = o_q.we[CLS_MEM];
    assign mem_rst_addr = o_q.m_addr;
    assign mem_rst_data = o_q.m_data;
    assign spr_rst_we   = o_q.we[CLS_SPR];
    assign spr_rst_addr = o_q.s_addr;
    assign spr_rst_data = o_q.s_data;
    assign log_ovf      = lg_ovf;

endmodule

// File: rtl/ckpt_undo_chk.sv
module ckpt_undo_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       gpr_wr_vld,
    input logic       mem_wr_vld,
    input logic       spr_wr_vld,
    input logic       commit,
    input logic       gpr_rst_we,
    input logic       mem_rst_we,
    input logic       spr_rst_we,
    input logic       busy,
    input logic       done,
    input logic       rcv_invalid,
    input logic [2:0] log_ovf,
    input logic [2:0] lg_empty
);
    AST_RESTORE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gpr_rst_we, mem_rst_we, spr_rst_we})); // R6

    AST_RESTORE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (gpr_rst_we || mem_rst_we || spr_rst_we) |-> $past(busy)); // R2

    AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !rcv_invalid) |-> (!busy && $past(busy))); // R7

    AST_INVALID_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        rcv_invalid |-> (done && !busy && !$past(busy))); // R8

    AST_COMMIT_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !busy && !gpr_wr_vld && !mem_wr_vld && !spr_wr_vld)
        |=> (lg_empty == 3'b111 && log_ovf == 3'b000)); // R5

    AST_OVF_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(log_ovf)); // R9

endmodule

bind ckpt_undo_unit ckpt_undo_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .gpr_wr_vld  (gpr_wr_vld),
    .mem_wr_vld  (mem_wr_vld),
    .spr_wr_vld  (spr_wr_vld),
    .commit      (commit),
    .gpr_rst_we  (gpr_rst_we),
    .mem_rst_we  (mem_rst_we),
    .spr_rst_we  (spr_rst_we),
    .busy        (busy),
    .done        (done),
    .rcv_invalid (rcv_invalid),
    .log_ovf     (log_ovf),
    .lg_empty    (lg_empty)
);

// File: tb/ckpt_undo_unit_tb_top.sv
module ckpt_undo_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int REG_AW = 4;
    localparam int MEM_AW = 8;
    localparam int SPR_AW = 2;
    localparam int DW     = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              gpr_wr_vld = 1'b0, mem_wr_vld = 1'b0, spr_wr_vld = 1'b0;
    logic [REG_AW-1:0] gpr_wr_addr = '0;
    logic [MEM_AW-1:0] mem_wr_addr = '0;
    logic [SPR_AW-1:0] spr_wr_addr = '0;
    logic [DW-1:0]     gpr_wr_old = '0, mem_wr_old = '0, spr_wr_old = '0;
    logic              commit = 1'b0, rcv_gpr = 1'b0, rcv_mem = 1'b0, rcv_spr = 1'b0;
    logic              gpr_rst_we, mem_rst_we, spr_rst_we;
    logic [REG_AW-1:0] gpr_rst_addr;
    logic [MEM_AW-1:0] mem_rst_addr;
    logic [SPR_AW-1:0] spr_rst_addr;
    logic [DW-1:0]     gpr_rst_data, mem_rst_data, spr_rst_data;
    logic              busy, done, rcv_invalid;
    logic [2:0]        log_ovf;

    int n_chk = 0;
    int n_fail = 0;
    int cap_a [0:63];
    int cap_d [0:63];

    always #(CLK_PERIOD/2) clk = ~clk;

    ckpt_undo_unit dut_i (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr_g(input int a, input int d);
        gpr_wr_vld = 1'b1; gpr_wr_addr = REG_AW'(a); gpr_wr_old = DW'(d);
        @(negedge clk);
        gpr_wr_vld = 1'b0;
    endtask

    task automatic wr_m(input int a, input int d);
        mem_wr_vld = 1'b1; mem_wr_addr = MEM_AW'(a); mem_wr_old = DW'(d);
        @(negedge clk);
        mem_wr_vld = 1'b0;
    endtask

    task automatic wr_s(input int a, input int d);
        spr_wr_vld = 1'b1; spr_wr_addr = SPR_AW'(a); spr_wr_old = DW'(d);
        @(negedge clk);
        spr_wr_vld = 1'b0;
    endtask

    task automatic do_commit();
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
    endtask

    // issue commands, capture writes on port cls until done
    task automatic run_rcv(input logic [2:0] cmds, input int cls, input bit disturb,
                           output int nw, output int dcyc, output bit inv,
                           output int other, output bit b0);
        nw = 0; dcyc = -1; inv = 1'b0; other = 0; b0 = 1'b0;
        rcv_gpr = cmds[0]; rcv_mem = cmds[1]; rcv_spr = cmds[2];
        @(negedge clk);
        rcv_gpr = 1'b0; rcv_mem = 1'b0; rcv_spr = 1'b0;
        b0 = busy;
        for (int c = 0; c < 40 && dcyc < 0; c++) begin
            if (c > 0) @(negedge clk);
            if (c == 1) begin
                mem_wr_vld = 1'b0; commit = 1'b0; rcv_mem = 1'b0;
            end
            if (cls == 0 && gpr_rst_we) begin cap_a[nw] = int'(gpr_rst_addr); cap_d[nw] = int'(gpr_rst_data); nw++; end
            else if (cls == 1 && mem_rst_we) begin cap_a[nw] = int'(mem_rst_addr); cap_d[nw] = int'(mem_rst_data); nw++; end
            else if (cls == 2 && spr_rst_we) begin cap_a[nw] = int'(spr_rst_addr); cap_d[nw] = int'(spr_rst_data); nw++; end
            if ((cls != 0 && gpr_rst_we) || (cls != 1 && mem_rst_we) || (cls != 2 && spr_rst_we)) other++;
            if (done) begin dcyc = c; inv = rcv_invalid; end
            if (c == 0 && disturb) begin
                mem_wr_vld = 1'b1; mem_wr_addr = 8'h55; mem_wr_old = 16'hdead;
                commit = 1'b1; rcv_mem = 1'b1;
            end
        end
    endtask

    task automatic exp_entry(input int i, input int a, input int d, input string req);
        chk(cap_a[i] == a && cap_d[i] == d, req, $sformatf("entry %0d", i),
            (longint'(cap_a[i]) << 16) | cap_d[i], (longint'(a) << 16) | d);
    endtask

    task automatic t_reset();
        chk(!busy && !done && !rcv_invalid, "R1", "flags", {busy, done, rcv_invalid}, 0);
        chk(!gpr_rst_we && !mem_rst_we && !spr_rst_we, "R1", "we",
            {gpr_rst_we, mem_rst_we, spr_rst_we}, 0);
        chk(log_ovf == 3'b000, "R1", "log_ovf", log_ovf, 0);
    endtask

    task automatic t_gpr_basic();
        int nw, dc, ot; bit inv, b0;
        do_commit();
        wr_g(3, 16'h1111); wr_g(5, 16'h2222); wr_g(3, 16'h3333); wr_g(7, 16'h4444);
        run_rcv(3'b001, 0, 1'b0, nw, dc, inv, ot, b0);
        chk(b0 == 1'b1, "R2", "busy after command", b0, 1);
        chk(nw == 3, "R4", "gpr entries", nw, 3);
        exp_entry(0, 7, 16'h4444, "R2");
        exp_entry(1, 5, 16'h2222, "R2");
        exp_entry(2, 3, 16'h1111, "R4");
        chk(dc == 4 && !inv, "R7", "done cycle", dc, 4);
        chk(ot == 0, "R6", "other ports", ot, 0);
        run_rcv(3'b001, 0, 1'b0, nw, dc, inv, ot, b0);
        chk(nw == 0 && dc == 1, "R7", "empty restore", {nw, dc}, 1);
        wr_g(3, 16'h5555);
        run_rcv(3'b001, 0, 1'b0, nw, dc, inv, ot, b0);
        chk(nw == 1, "R4", "relog after restore", nw, 1);
        exp_entry(0, 3, 16'h5555, "R4");
    endtask

    task automatic t_mem_repeat();
        int nw, dc, ot; bit inv, b0;
        do_commit();
        wr_m(8'h10, 16'haaaa); wr_m(8'h20, 16'hbbbb); wr_m(8'h10, 16'hcccc);
        run_rcv(3'b010, 1, 1'b0, nw, dc, inv, ot, b0);
        chk(nw == 3 && dc == 4, "R3", "mem count/done", {nw, dc}, {32'd3, 32'd4});
        exp_entry(0, 8'h10, 16'hcccc, "R3");
        exp_entry(1, 8'h20, 16'hbbbb, "R3");
        exp_entry(2, 8'h10, 16'haaaa, "R3");
    endtask

    task automatic t_spr_dirty();
        int nw, dc, ot; bit inv, b0;
        do_commit();
        wr_s(1, 16'h0101); wr_s(1, 16'h0202); wr_s(2, 16'h0303);
        run_rcv(3'b100, 2, 1'b0, nw, dc, inv, ot, b0);
        chk(nw == 2, "R4", "spr entries", nw, 2);
        exp_entry(0, 2, 16'h0303, "R4");
        exp_entry(1, 1, 16'h0101, "R4");
        chk(ot == 0, "R6", "other ports spr", ot, 0);
    endtask

    task automatic t_commit();
        int nw, dc, ot; bit inv, b0;
        do_commit();
        wr_g(1, 16'h7777); wr_m(2, 16'h8888); wr_s(0, 16'h9999);
        do_commit();
        run_rcv(3'b010, 1, 1'b0, nw, dc, inv, ot, b0);
        chk(nw == 0 && dc == 1, "R5", "mem after commit", nw, 0);
        run_rcv(3'b100, 2, 1'b0, nw, dc, inv, ot, b0);
        chk(nw == 0, "R5", "spr after commit", nw, 0);
        wr_g(1, 16'h1234);
        gpr_wr_vld = 1'b1; gpr_wr_addr = 4'd9; gpr_wr_old = 16'h0909; commit = 1'b1;
        @(negedge clk);
        gpr_wr_vld = 1'b0; commit = 1'b0;
        wr_g(9, 16'hffff);
        run_rcv(3'b001, 0, 1'b0, nw, dc, inv, ot, b0);
        chk(nw == 1, "R5", "write with commit logged", nw, 1);
        exp_entry(0, 9, 16'h0909, "R5");
    endtask

    task automatic t_priority();
        int nw, dc, ot; bit inv, b0;
        do_commit();
        wr_g(2, 16'h0a0a); wr_m(4, 16'h0b0b);
        run_rcv(3'b111, 0, 1'b0, nw, dc, inv, ot, b0);
        chk(nw == 1 && ot == 0, "R6", "gpr wins", {nw, ot}, 1);
        run_rcv(3'b010, 1, 1'b0, nw, dc, inv, ot, b0);
        chk(nw == 1, "R6", "mem untouched", nw, 1);
        exp_entry(0, 4, 16'h0b0b, "R6");
    endtask

    task automatic t_overflow();
        int nw, dc, ot; bit inv, b0;
        do_commit();
        for (int i = 0; i < 9; i++) wr_m(i, 16'h0c00 + i);
        chk(log_ovf == 3'b010, "R8", "ovf flag", log_ovf, 3'b010);
        run_rcv(3'b010, 1, 1'b0, nw, dc, inv, ot, b0);
        chk(dc == 0 && inv && nw == 0 && !b0, "R8", "invalid restore",
            {dc, 31'(nw), inv}, 1);
        do_commit();
        chk(log_ovf == 3'b000, "R5", "ovf cleared", log_ovf, 0);
    endtask

    task automatic t_busy_ignore();
        int nw, dc, ot; bit inv, b0;
        do_commit();
        wr_g(1, 16'h0d01); wr_g(2, 16'h0d02);
        run_rcv(3'b001, 0, 1'b1, nw, dc, inv, ot, b0);
        chk(nw == 2 && dc == 3, "R9", "commit ignored in run", {nw, dc}, {32'd2, 32'd3});
        @(negedge clk);
        chk(!done && !busy, "R9", "no queued command", {done, busy}, 0);
        run_rcv(3'b010, 1, 1'b0, nw, dc, inv, ot, b0);
        chk(nw == 0, "R9", "write ignored in run", nw, 0);
    endtask

    task automatic t_full();
        int nw, dc, ot, total; bit inv, b0;
        total = 0;
        do_commit();
        for (int i = 0; i < 8; i++) wr_g(i, 16'h0100 + i);
        for (int i = 0; i < 8; i++) wr_m(8'h80 + i, 16'h0200 + i);
        for (int i = 0; i < 4; i++) wr_s(i, 16'h0300 + i);
        chk(log_ovf == 3'b000, "R7", "full no ovf", log_ovf, 0);
        run_rcv(3'b001, 0, 1'b0, nw, dc, inv, ot, b0);
        chk(nw == 8 && dc == 9, "R7", "gpr full", {nw, dc}, {32'd8, 32'd9});
        exp_entry(0, 7, 16'h0107, "R2");
        total += dc + 1;
        run_rcv(3'b010, 1, 1'b0, nw, dc, inv, ot, b0);
        chk(nw == 8 && dc == 9, "R7", "mem full", {nw, dc}, {32'd8, 32'd9});
        exp_entry(7, 8'h80, 16'h0200, "R3");
        total += dc + 1;
        run_rcv(3'b100, 2, 1'b0, nw, dc, inv, ot, b0);
        chk(nw == 4 && dc == 5, "R7", "spr full", {nw, dc}, {32'd4, 32'd5});
        total += dc + 1;
        chk(total <= 62, "R7", "total cycles", total, 62);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_gpr_basic();
        t_mem_repeat();
        t_spr_dirty();
        t_commit();
        t_priority();
        t_overflow();
        t_busy_ignore();
        t_full();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule